// File: doc/BRIEF.md
# External Bus Wait-State Generator

This block stretches external bus accesses by a programmable number of stall cycles. Each access arrives as a one-cycle request that carries an address-space code (program, data or I/O) and an address. The block uses the space and the address to pick one of five 3-bit base counts held in a 16-bit timing register. It can double that count through a bit in a separate control register. It then holds a stall output high for that many cycles and signals completion with a one-cycle done pulse.

Both registers sit behind a small memory-mapped register port. Writes are synchronous. Reads are combinational from the addressed register. The bus sequencer in front of this block issues one request, waits for done, and only then issues the next one.

The program-space split depends on a mode bit in the timing register. In paged mode, address bit 15 splits every 64K page into a lower and an upper half, whatever the upper address bits are. In linear mode, address bit 22 splits the 23-bit program space into two halves.

Top module: `ext_wait_gen`

## Requirements
- R1: After reset the timing register reads 7FFFh, the control register reads 0000h, and acc_stall and acc_done are both low.
- R2: The timing register is at address CFG_ADDR and all 16 bits can be written and read back. A read of any address that is neither CFG_ADDR nor CTL_ADDR returns 0000h.
- R3: The control register is at CTL_ADDR (002Bh). Bit 0 is the doubling bit and can be written and read. Bits 15:1 always read 0, whatever is written to them.
- R4: An access with space code 2'b10 (I/O), or with the unused code 2'b11, takes its base count from timing bits 14:12 for every address.
- R5: A data access (space code 2'b01) takes its base count from timing bits 11:9 when address bit 15 is 1, and from bits 8:6 when it is 0.
- R6: A program access (space code 2'b00) with timing bit 15 clear takes bits 5:3 when address bit 15 is 1, and bits 2:0 when it is 0. Address bits 22:16 have no effect.
- R7: A program access with timing bit 15 set takes bits 5:3 when address bit 22 is 1 (400000h–7FFFFFh), and bits 2:0 when it is 0.
- R8: With control bit 0 set, the selected base count is doubled. The longest possible stall is therefore 14 cycles.
- R9: A request accepted at a clock edge with an effective count N > 0 drives acc_stall high for exactly N cycles, starting from that edge. acc_done then goes high for exactly one cycle, and acc_stall is low during that cycle.
- R10: An effective count of 0 gives acc_done for one cycle directly after the accepting edge, and acc_stall stays low throughout.
- R11: The effective count is captured when the request is accepted. Register writes made while the access is in progress do not change its length.
- R12: A request is accepted only while acc_stall and acc_done are both low. A request raised during an access is dropped and starts no later access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_en | input | 1 | Register port select |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | REG_AW (16) | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the addressed register |
| acc_req | input | 1 | Access request, sampled at the clock edge |
| acc_space | input | 2 | 00 program, 01 data, 10 I/O, 11 treated as I/O |
| acc_addr | input | ADDR_W (23) | Access address |
| acc_stall | output | 1 | Not-ready: high while wait cycles are being inserted |
| acc_done | output | 1 | One-cycle access completion |

## Verification
The bench builds the block with its default parameters: 3-bit count fields, a 23-bit program address, 16-bit register addresses, and the timing register at 0028h next to the control register at 002Bh. At these widths the bench can reach the top program-address bit (bit 22) that sets the linear-mode split. It can also test the page split at bit 15 with the upper bits set, and it can drive a doubled count of 7 to reach the 14-cycle maximum stall. With the register port 16 bits wide, the bench can write the reserved control bits and confirm that they read back as zero.

// File: rtl/ext_wait_pkg.sv
// Package: shared encodings for the external bus wait-state generator.
// Assumes: a 2-bit access space code and five count fields in a fixed order.
package ext_wait_pkg;

    typedef enum logic [1:0] {
        SP_PROG = 2'b00,
        SP_DATA = 2'b01,
        SP_IO   = 2'b10,
        SP_RSVD = 2'b11
    } acc_space_e;

    // Index of each count field inside the timing register, lowest first
    localparam int unsigned FLD_PROG_LO = 0;
    localparam int unsigned FLD_PROG_HI = 1;
    localparam int unsigned FLD_DATA_LO = 2;
    localparam int unsigned FLD_DATA_HI = 3;
    localparam int unsigned FLD_IO      = 4;
    localparam int unsigned NUM_FLD     = 5;

    // Address bit that splits a 64K page into halves
    localparam int unsigned PAGE_SPLIT_BIT = 15;

endpackage

// File: rtl/ewg_cfg_regs.sv
// ewg_cfg_regs: holds the timing register and the control register.
// Assumes: a synchronous write when reg_en && reg_we; reads are combinational
// and return zero for unmapped addresses. The reserved control bits are not stored.
module ewg_cfg_regs #(
    parameter int unsigned       REG_DW   = 16,
    parameter int unsigned       REG_AW   = 16,
    parameter logic [REG_AW-1:0] CFG_ADDR = 16'h0028,
    parameter logic [REG_AW-1:0] CTL_ADDR = 16'h002B
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_en,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    output logic [REG_DW-1:0] timing_q,
    output logic              dbl_q
);
    // All count fields at their maximum, mode bit clear
    localparam logic [REG_DW-1:0] TIMING_RST = {1'b0, {(REG_DW-1){1'b1}}};

    logic hit_cfg;
    logic hit_ctl;

    assign hit_cfg = (reg_addr == CFG_ADDR);
    assign hit_ctl = (reg_addr == CTL_ADDR);

    // Purpose: store register writes and return both registers to their reset values
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            timing_q <= TIMING_RST;
            dbl_q    <= 1'b0;
        end else if (reg_en && reg_we) begin
            if (hit_cfg) timing_q <= reg_wdata;
            if (hit_ctl) dbl_q    <= reg_wdata[0];
        end
    end

    // Purpose: read multiplexer; the reserved control bits always read zero
    always_comb begin
        reg_rdata = '0;
        if (reg_en && !reg_we) begin
            if (hit_cfg)      reg_rdata = timing_q;
            else if (hit_ctl) reg_rdata = {{(REG_DW-1){1'b0}}, dbl_q};
        end
    end

endmodule

// File: rtl/ewg_region_sel.sv
// ewg_region_sel: selects the base count for one access from its space and
// address, then applies the doubling bit.
// Assumes: the timing register holds NUM_FLD count fields of CNT_W bits, with
// the program-mode bit directly above them, and ADDR_W > 16.
module ewg_region_sel
    import ext_wait_pkg::*;
#(
    parameter int unsigned CNT_W  = 3,
    parameter int unsigned ADDR_W = 23,
    parameter int unsigned REG_DW = NUM_FLD * CNT_W + 1,
    parameter int unsigned EFF_W  = CNT_W + 1
) (
    input  logic [REG_DW-1:0] timing,
    input  logic              dbl,
    input  logic [1:0]        space,
    input  logic [ADDR_W-1:0] addr,
    output logic [EFF_W-1:0]  eff_cnt
);
    localparam int unsigned MODE_BIT = NUM_FLD * CNT_W;

    logic [CNT_W-1:0] fld [NUM_FLD];
    logic             linear_mode;
    logic             prog_upper;
    logic [CNT_W-1:0] base;

    // Unpack every count field from the timing register
    for (genvar g = 0; g < NUM_FLD; g++) begin : g_fld
        assign fld[g] = timing[g*CNT_W +: CNT_W];
    end

    assign linear_mode = timing[MODE_BIT];
    assign prog_upper  = linear_mode ? addr[ADDR_W-1] : addr[PAGE_SPLIT_BIT];

    // Purpose: pick the count field that matches the access region
    always_comb begin
        case (acc_space_e'(space))
            SP_PROG: base = prog_upper ? fld[FLD_PROG_HI] : fld[FLD_PROG_LO];
            SP_DATA: base = addr[PAGE_SPLIT_BIT] ? fld[FLD_DATA_HI] : fld[FLD_DATA_LO];
            default: base = fld[FLD_IO];
        endcase
    end

    // Purpose: doubling is a left shift into the extra count bit
    assign eff_cnt = dbl ? {base, 1'b0} : {1'b0, base};

endmodule

// File: rtl/ewg_wait_ctr.sv
// ewg_wait_ctr: accepts a request, counts down the captured wait count while
// holding stall, then pulses done for one cycle.
// Assumes: a request is accepted only while both stall and done are low; a
// count of zero goes straight to done.
module ewg_wait_ctr #(
    parameter int unsigned EFF_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic [EFF_W-1:0] eff_cnt,
    output logic             stall,
    output logic             done
);
    logic [EFF_W-1:0] remain_q;
    logic             accept;

    assign accept = req && !stall && !done;

    // Purpose: sequence idle, then stall for N cycles, then a single done cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
            stall    <= 1'b0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                remain_q <= eff_cnt;
                if (eff_cnt == '0) done  <= 1'b1;
                else               stall <= 1'b1;
            end else if (stall) begin
                if (remain_q == EFF_W'(1)) begin
                    stall <= 1'b0;
                    done  <= 1'b1;
                end
                remain_q <= remain_q - EFF_W'(1);
            end
        end
    end

endmodule

// File: rtl/ext_wait_gen.sv
// ext_wait_gen: top of the external bus wait-state generator. It joins the
// register block, the region selector and the wait counter.
// Assumes: a synchronous active-low reset and a requester that waits for done
// before it issues the next access.
module ext_wait_gen
    import ext_wait_pkg::*;
#(
    parameter int unsigned       CNT_W    = 3,
    parameter int unsigned       ADDR_W   = 23,
    parameter int unsigned       REG_AW   = 16,
    parameter logic [REG_AW-1:0] CFG_ADDR = 16'h0028,
    parameter logic [REG_AW-1:0] CTL_ADDR = 16'h002B,
    localparam int unsigned      REG_DW   = NUM_FLD * CNT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_en,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    input  logic              acc_req,
    input  logic [1:0]        acc_space,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic              acc_stall,
    output logic              acc_done
);
    localparam int unsigned EFF_W = CNT_W + 1;

    logic [REG_DW-1:0] timing_q;
    logic              dbl_q;
    logic [EFF_W-1:0]  eff_cnt;

    ewg_cfg_regs #(
        .REG_DW   (REG_DW),
        .REG_AW   (REG_AW),
        .CFG_ADDR (CFG_ADDR),
        .CTL_ADDR (CTL_ADDR)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_en    (reg_en),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .timing_q  (timing_q),
        .dbl_q     (dbl_q)
    );

    ewg_region_sel #(
        .CNT_W  (CNT_W),
        .ADDR_W (ADDR_W),
        .REG_DW (REG_DW),
        .EFF_W  (EFF_W)
    ) u_sel (
        .timing  (timing_q),
        .dbl     (dbl_q),
        .space   (acc_space),
        .addr    (acc_addr),
        .eff_cnt (eff_cnt)
    );

    ewg_wait_ctr #(
        .EFF_W (EFF_W)
    ) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (acc_req),
        .eff_cnt (eff_cnt),
        .stall   (acc_stall),
        .done    (acc_done)
    );

endmodule

// File: rtl/ext_wait_gen_chk.sv
// ext_wait_gen_chk: protocol checker for ext_wait_gen, attached to it by bind.
// Assumes: it can see the top-level ports only.
module ext_wait_gen_chk #(
    parameter int unsigned       REG_AW   = 16,
    parameter int unsigned       REG_DW   = 16,
    parameter logic [REG_AW-1:0] CTL_ADDR = 16'h002B
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_en,
    input logic              reg_we,
    input logic [REG_AW-1:0] reg_addr,
    input logic [REG_DW-1:0] reg_rdata,
    input logic              acc_stall,
    input logic              acc_done
);
    logic [4:0] stall_run;

    // Purpose: count consecutive stall cycles, saturating
    always_ff @(posedge clk) begin
        if (!rst_n)                    stall_run <= '0;
        else if (!acc_stall)           stall_run <= '0;
        else if (stall_run != 5'd31)   stall_run <= stall_run + 5'd1;
    end

    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!acc_stall && !acc_done));

    a_r3_ctl_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_en && !reg_we && reg_addr == CTL_ADDR) |-> (reg_rdata[REG_DW-1:1] == '0));

    a_r8_max_fourteen: assert property (@(posedge clk) disable iff (!rst_n)
        acc_stall |-> (stall_run < 5'd14));

    a_r9_done_after_stall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(acc_stall) |-> acc_done);

    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        acc_done |=> !acc_done);

    a_r9_stall_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_stall && acc_done));

    a_r12_no_stall_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        acc_done |=> !acc_stall);

endmodule

bind ext_wait_gen ext_wait_gen_chk #(
    .REG_AW   (REG_AW),
    .REG_DW   (REG_DW),
    .CTL_ADDR (CTL_ADDR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_en    (reg_en),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .acc_stall (acc_stall),
    .acc_done  (acc_done)
);

// File: tb/ext_wait_gen_tb.sv
// ext_wait_gen_tb: directed bench, one task per scenario.
module ext_wait_gen_tb;

    localparam logic [15:0] CFG = 16'h0028;
    localparam logic [15:0] CTL = 16'h002B;
    localparam logic [1:0]  PRG = 2'b00, DAT = 2'b01, IOS = 2'b10, RSV = 2'b11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_en = 1'b0, reg_we = 1'b0;
    logic [15:0] reg_addr = '0, reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        acc_req = 1'b0;
    logic [1:0]  acc_space = '0;
    logic [22:0] acc_addr = '0;
    logic        acc_stall, acc_done;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    ext_wait_gen u_dut (
        .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .acc_req(acc_req), .acc_space(acc_space), .acc_addr(acc_addr),
        .acc_stall(acc_stall), .acc_done(acc_done)
    );

    task automatic check(input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_en = 1'b0; reg_we = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b0; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_en = 1'b0;
    endtask

    // One access: count the stall cycles before done, then check that done lasts one cycle
    task automatic run_access(input logic [1:0] sp, input logic [22:0] a,
                              input int exp, input string tag);
        int n = 0;
        bit seen = 1'b0;
        @(negedge clk);
        acc_space = sp; acc_addr = a; acc_req = 1'b1;
        @(negedge clk);
        acc_req = 1'b0;
        for (int i = 0; i < 40 && !seen; i++) begin
            if (acc_done) seen = 1'b1;
            else begin
                if (acc_stall) n++;
                @(negedge clk);
            end
        end
        check(n, exp, {tag, " stall cycles"});
        check(int'(seen), 1, {tag, " done seen"});
        @(negedge clk);
        check(int'(acc_done), 0, {tag, " done one cycle"});
    endtask

    task automatic t_reset;
        logic [15:0] d;
        check(int'(acc_stall), 0, "R1 stall after reset");
        check(int'(acc_done), 0, "R1 done after reset");
        rd(CFG, d); check(int'(d), 16'h7FFF, "R1 timing reset");
        rd(CTL, d); check(int'(d), 0, "R1 control reset");
        run_access(IOS, 23'h0, 7, "R9 reset count");
    endtask

    task automatic t_regs;
        logic [15:0] d;
        wr(CFG, 16'hA5C3); rd(CFG, d); check(int'(d), 16'hA5C3, "R2 timing readback");
        wr(16'h0010, 16'hFFFF); rd(16'h0010, d); check(int'(d), 0, "R2 unmapped read");
        wr(CTL, 16'hFFFF); rd(CTL, d); check(int'(d), 1, "R3 reserved bits zero");
        wr(CTL, 16'h0000); rd(CTL, d); check(int'(d), 0, "R3 doubling bit clear");
    endtask

    task automatic t_io;
        wr(CFG, 16'h3000 | 16'h0FFF);
        run_access(IOS, 23'h001234, 3, "R4 io");
        run_access(IOS, 23'h00FFFF, 3, "R4 io top");
        run_access(RSV, 23'h000000, 3, "R4 unused code");
    endtask

    task automatic t_data;
        wr(CFG, (16'd5 << 9) | (16'd2 << 6));
        run_access(DAT, 23'h007FFF, 2, "R5 data lower");
        run_access(DAT, 23'h008000, 5, "R5 data upper");
    endtask

    task automatic t_prog_page;
        wr(CFG, (16'd6 << 3) | 16'd1);
        run_access(PRG, 23'h7F7FFF, 1, "R6 page lower");
        run_access(PRG, 23'h008000, 6, "R6 page upper");
    endtask

    task automatic t_prog_linear;
        wr(CFG, 16'h8000 | (16'd6 << 3) | 16'd1);
        run_access(PRG, 23'h3FFFFF, 1, "R7 linear lower");
        run_access(PRG, 23'h400000, 6, "R7 linear upper");
    endtask

    task automatic t_mult;
        wr(CFG, 16'h7000 | (16'd3 << 6));
        wr(CTL, 16'h0001);
        run_access(IOS, 23'h000100, 14, "R8 doubled max");
        run_access(DAT, 23'h000100, 6, "R8 doubled data");
        wr(CTL, 16'h0000);
    endtask

    task automatic t_zero;
        wr(CFG, 16'h0000);
        run_access(DAT, 23'h000010, 0, "R10 zero count");
    endtask

    // Writes to both registers while the access stalls must not change its length
    task automatic t_latch;
        int n = 0;
        bit seen = 1'b0;
        wr(CFG, 16'h5000);
        @(negedge clk);
        acc_space = IOS; acc_addr = 23'h0; acc_req = 1'b1;
        @(negedge clk);
        acc_req = 1'b0;
        for (int i = 0; i < 40 && !seen; i++) begin
            if (acc_done) seen = 1'b1;
            else begin
                if (acc_stall) n++;
                if (i == 1) begin reg_en = 1'b1; reg_we = 1'b1; reg_addr = CFG; reg_wdata = 16'h1000; end
                if (i == 2) begin reg_addr = CTL; reg_wdata = 16'h0001; end
                if (i == 3) begin reg_en = 1'b0; reg_we = 1'b0; end
                @(negedge clk);
            end
        end
        check(n, 5, "R11 captured length");
        check(int'(seen), 1, "R11 done seen");
        wr(CTL, 16'h0000);
        run_access(IOS, 23'h0, 1, "R11 new value next access");
    endtask

    // A request raised during the stall must be dropped
    task automatic t_busy;
        int n = 0;
        int late = 0;
        bit seen = 1'b0;
        wr(CFG, 16'h4000);
        @(negedge clk);
        acc_space = IOS; acc_addr = 23'h0; acc_req = 1'b1;
        @(negedge clk);
        acc_req = 1'b0;
        for (int i = 0; i < 40 && !seen; i++) begin
            if (acc_done) seen = 1'b1;
            else begin
                if (acc_stall) n++;
                if (i == 1) acc_req = 1'b1;
                if (i == 3) acc_req = 1'b0;
                @(negedge clk);
            end
        end
        check(n, 4, "R12 first access length");
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (acc_stall || acc_done) late++;
        end
        check(late, 0, "R12 dropped request");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_io();
        t_data();
        t_prog_page();
        t_prog_linear();
        t_mult();
        t_zero();
        t_latch();
        t_busy();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule